// File: doc/BRIEF.md
# Real-time seconds/milliseconds counter with coherent shadow read

The block keeps time as a 32-bit seconds count plus a millisecond count. It advances from a slow tick strobe of nominally 32768 Hz. A fractional accumulator turns that strobe into millisecond steps. The millisecond count rolls over at a parameterised wrap value and carries into the seconds count. A host reaches the block over a small memory-mapped register port: one select, one write flag, an 8-bit offset, and 32-bit data. Read data is combinational.

The values the host reads are bus-side copies of the running counters. The copies are refreshed once every `COPY_PERIOD` slow ticks. For the whole slow-tick interval before each refresh, a busy flag reads as 1, and the block drops any host write made in that interval. Reading the millisecond register also captures the bus-side seconds copy into a shadow register in the same access, so the host can read a matching seconds/milliseconds pair.

Two alarms drive a sticky status register:
- A seconds-match alarm fires when the seconds count steps onto the programmed value. A programmed value of zero turns this alarm off.
- A repeating countdown alarm fires every N seconds.

Status bits are cleared by writing 1 to them. A mask register selects which status bits drive the active-high level interrupt.

Top module: `rtc_shadow_timer`

## Requirements
- R1: After synchronous reset, every register reads 0: busy, seconds, shadow, milliseconds, alarm, countdown, status and mask. `irq` is 0.
- R2: On each tick, `MS_HZ` is added to an accumulator. When the sum reaches `TICK_HZ`, `TICK_HZ` is subtracted and the internal millisecond count steps by 1. At `MS_WRAP` the millisecond count returns to 0 and the seconds count steps by 1.
- R3: The busy register (offset 0x04, bit 0) reads 1 during the last tick interval of every `COPY_PERIOD` ticks. The tick that ends that interval copies the internal seconds and milliseconds values, as they stood before that tick, into the bus-side values. The seconds register (0x08) and milliseconds register (0x10) return those bus-side values.
- R4: A read of the milliseconds register (0x10) loads the bus-side seconds value into the shadow register (0x0C) at the end of that access.
- R5: An accepted write to the seconds register (0x08) loads both the internal and bus-side seconds. It also clears the millisecond count and the accumulator.
- R6: Any write made while busy reads 1 is discarded, with no error indication.
- R7: The alarm register is at 0x14. When it holds a nonzero value, status bit 0 is set on the tick where the seconds count steps onto that value. When it holds 0, that bit is never set.
- R8: The countdown register (0x18) takes a reload value N. When N is nonzero, status bit 1 is set every N seconds counted from the write. A read of 0x18 returns the seconds remaining. When N is 0, the countdown is off.
- R9: The status register is at 0x1C, with bit 0 for the alarm and bit 1 for the countdown. Writing 1 to a bit clears it, and writing all ones clears both bits. Otherwise a set bit stays set whatever the mask.
- R10: The mask register (0x20) uses the same bit positions as status. `irq` is 1 exactly while some status bit and the matching mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| tick_32k | input | 1 | one-cycle strobe per slow-clock tick |
| bus_sel | input | 1 | register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | register byte offset |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for the addressed register |
| irq | output | 1 | level interrupt, active high |

## Verification
The bench uses a small timebase: two ticks per millisecond, four milliseconds per second, and a copy every eight ticks. It sweeps many seconds tick by tick and compares busy, milliseconds, shadow and seconds against an arithmetic model.

A design that copies post-increment values, or places the busy interval in the wrong phase, will read one step off at the copy boundaries. A design that takes the shadow from the live counter instead of the bus-side copy returns a seconds value that does not match the milliseconds just read.

The bench also writes to the seconds, alarm and mask registers while busy is 1; a design that accepts those writes changes the read-back values. A design that compares a zero alarm against the seconds count, lets the mask gate the status bits, or restarts the countdown at the wrong count sets or drops status bits one tick away from where the model expects them.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int ST_BITS  = 2;
    localparam int ST_ALARM = 0;
    localparam int ST_CDOWN = 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_BUSY   = 8'h04,
        REG_SEC    = 8'h08,
        REG_SHADOW = 8'h0C,
        REG_MSEC   = 8'h10,
        REG_ALARM  = 8'h14,
        REG_CDOWN  = 8'h18,
        REG_STATUS = 8'h1C,
        REG_MASK   = 8'h20
    } reg_addr_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic wr_hit(wr_req_t w, reg_addr_e a);
        return w.en && (w.addr == a);
    endfunction
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase
    import rtc_pkg::*;
#(
    parameter int TICK_HZ     = 32768,
    parameter int MS_HZ       = 1000,
    parameter int MS_WRAP     = 1000,
    parameter int COPY_PERIOD = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    output logic              busy,
    output logic [DATA_W-1:0] vis_sec,
    output logic [$clog2(MS_WRAP+1)-1:0] vis_ms,
    output logic              sec_roll,
    output logic [DATA_W-1:0] sec_next
);
    localparam int ACC_W = $clog2(TICK_HZ) + 1;
    localparam int MS_W  = $clog2(MS_WRAP + 1);
    localparam int PH_W  = $clog2(COPY_PERIOD);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(COPY_PERIOD - 1);

    logic [ACC_W-1:0]  acc_q, acc_sum;
    logic [MS_W-1:0]   ms_q;
    logic [DATA_W-1:0] sec_q;
    logic [PH_W-1:0]   phase_q;
    logic              ms_step;

    always_comb begin
        acc_sum  = acc_q + ACC_W'(MS_HZ);
        ms_step  = tick && (acc_sum >= ACC_W'(TICK_HZ));
        sec_roll = ms_step && (ms_q == MS_W'(MS_WRAP - 1));
        sec_next = sec_q + 1'b1;
        busy     = (phase_q == PH_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (tick)
            phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            ms_q    <= '0;
            sec_q   <= '0;
            vis_sec <= '0;
            vis_ms  <= '0;
        end else if (load_en) begin
            acc_q   <= '0;
            ms_q    <= '0;
            sec_q   <= load_val;
            vis_sec <= load_val;
            vis_ms  <= '0;
        end else if (tick) begin
            if (busy) begin
                vis_sec <= sec_q;
                vis_ms  <= ms_q;
            end
            if (ms_step) begin
                acc_q <= acc_sum - ACC_W'(TICK_HZ);
                if (sec_roll) begin
                    ms_q  <= '0;
                    sec_q <= sec_next;
                end else begin
                    ms_q <= ms_q + 1'b1;
                end
            end else begin
                acc_q <= acc_sum;
            end
        end
    end

    // R2: millisecond count never reaches the wrap value
    p_ms_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        ms_q < MS_W'(MS_WRAP));

    // R3: the copy tick exposes the pre-tick seconds value
    p_copy_pre_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && busy && !load_en) |=> (vis_sec == $past(sec_q)));
endmodule

// File: rtl/rtc_alarms.sv
module rtc_alarms
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  wr_req_t            wr,
    input  logic               sec_roll,
    input  logic [DATA_W-1:0]  sec_next,
    output logic [DATA_W-1:0]  alarm_q,
    output logic [DATA_W-1:0]  cdown_q,
    output logic [ST_BITS-1:0] status_q,
    output logic [ST_BITS-1:0] mask_q,
    output logic               irq
);
    logic [DATA_W-1:0]  reload_q;
    logic [ST_BITS-1:0] st_set, st_clr;

    always_comb begin
        st_set = '0;
        st_set[ST_ALARM] = sec_roll && (alarm_q != '0) && (alarm_q == sec_next);
        st_set[ST_CDOWN] = sec_roll && (reload_q != '0) && (cdown_q == DATA_W'(1));
        st_clr = wr_hit(wr, REG_STATUS) ? wr.data[ST_BITS-1:0] : '0;
        irq    = |(status_q & mask_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q  <= '0;
            reload_q <= '0;
            cdown_q  <= '0;
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= (status_q & ~st_clr) | st_set;
            if (wr_hit(wr, REG_ALARM))
                alarm_q <= wr.data;
            if (wr_hit(wr, REG_MASK))
                mask_q <= wr.data[ST_BITS-1:0];
            if (wr_hit(wr, REG_CDOWN)) begin
                reload_q <= wr.data;
                cdown_q  <= wr.data;
            end else if (sec_roll && reload_q != '0) begin
                cdown_q <= (cdown_q == DATA_W'(1)) ? reload_q : cdown_q - 1'b1;
            end
        end
    end

    // R9: alarm status holds until a write-one clear
    p_status_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (status_q[ST_ALARM] && !(wr_hit(wr, REG_STATUS) && wr.data[ST_ALARM]))
        |=> status_q[ST_ALARM]);

    // R7: a zero alarm value never raises the alarm status
    p_alarm_off_r7: assert property (@(posedge clk) disable iff (rst)
        (alarm_q == '0 && !status_q[ST_ALARM]) |=> !status_q[ST_ALARM]);
endmodule

// File: rtl/rtc_shadow_timer.sv
module rtc_shadow_timer
    import rtc_pkg::*;
#(
    parameter int TICK_HZ     = 32768,
    parameter int MS_HZ       = 1000,
    parameter int MS_WRAP     = 1000,
    parameter int COPY_PERIOD = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_32k,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int MS_W = $clog2(MS_WRAP + 1);

    logic               busy, sec_roll, ms_read;
    logic [DATA_W-1:0]  vis_sec, sec_next, shadow_q, alarm_q, cdown_q;
    logic [MS_W-1:0]    vis_ms;
    logic [ST_BITS-1:0] status_q, mask_q;
    wr_req_t            wr;

    always_comb begin
        wr.en   = bus_sel && bus_wr && !busy;
        wr.addr = bus_addr;
        wr.data = bus_wdata;
        ms_read = bus_sel && !bus_wr && (bus_addr == REG_MSEC);
    end

    rtc_timebase #(
        .TICK_HZ(TICK_HZ), .MS_HZ(MS_HZ), .MS_WRAP(MS_WRAP), .COPY_PERIOD(COPY_PERIOD)
    ) i_timebase (
        .clk(clk), .rst(rst), .tick(tick_32k),
        .load_en(wr_hit(wr, REG_SEC)), .load_val(bus_wdata),
        .busy(busy), .vis_sec(vis_sec), .vis_ms(vis_ms),
        .sec_roll(sec_roll), .sec_next(sec_next)
    );

    rtc_alarms i_alarms (
        .clk(clk), .rst(rst), .wr(wr),
        .sec_roll(sec_roll), .sec_next(sec_next),
        .alarm_q(alarm_q), .cdown_q(cdown_q),
        .status_q(status_q), .mask_q(mask_q), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst)
            shadow_q <= '0;
        else if (ms_read)
            shadow_q <= vis_sec;
    end

    always_comb begin
        case (bus_addr)
            REG_BUSY:   bus_rdata = DATA_W'(busy);
            REG_SEC:    bus_rdata = vis_sec;
            REG_SHADOW: bus_rdata = shadow_q;
            REG_MSEC:   bus_rdata = DATA_W'(vis_ms);
            REG_ALARM:  bus_rdata = alarm_q;
            REG_CDOWN:  bus_rdata = cdown_q;
            REG_STATUS: bus_rdata = DATA_W'(status_q);
            REG_MASK:   bus_rdata = DATA_W'(mask_q);
            default:    bus_rdata = '0;
        endcase
    end

    // R4: a millisecond read captures the bus-side seconds
    p_shadow_capture_r4: assert property (@(posedge clk) disable iff (rst)
        ms_read |=> (shadow_q == $past(vis_sec)));

    // R6: alarm value cannot change through a write during busy
    p_busy_write_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && busy && bus_addr == REG_ALARM) |=> $stable(alarm_q));
endmodule

// File: tb/test_rtc_shadow_timer.sv
module test_rtc_shadow_timer;
    localparam int TICK_HZ = 4, MS_HZ = 2, MS_WRAP = 4, COPY = 8;
    localparam logic [7:0] A_BUSY = 8'h04, A_SEC = 8'h08, A_SHD = 8'h0C, A_MS = 8'h10,
                           A_ALM = 8'h14, A_CDN = 8'h18, A_ST = 8'h1C, A_MSK = 8'h20;

    logic clk = 0, rst = 1, tick = 0, sel = 0, wr = 0;
    logic [7:0]  addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic        irq;
    int n_chk = 0, n_bad = 0;

    int unsigned m_acc, m_ms, m_phase, m_vms;
    logic [31:0] m_sec, m_vsec, m_shd, m_alm, m_rel, m_cnt;
    logic [1:0]  m_st, m_msk;

    rtc_shadow_timer #(.TICK_HZ(TICK_HZ), .MS_HZ(MS_HZ), .MS_WRAP(MS_WRAP), .COPY_PERIOD(COPY))
    i_rtc_shadow_timer (.clk(clk), .rst(rst), .tick_32k(tick), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

    always #5 clk = ~clk;

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic m_busy();
        return m_phase == COPY - 1;
    endfunction

    task automatic do_tick();
        @(posedge clk); #1 tick = 1;
        @(posedge clk); #1 tick = 0;
        if (m_busy()) begin m_vsec = m_sec; m_vms = m_ms; end
        m_phase = (m_phase + 1) % COPY;
        m_acc += MS_HZ;
        if (m_acc >= TICK_HZ) begin
            m_acc -= TICK_HZ;
            m_ms++;
            if (m_ms == MS_WRAP) begin
                m_ms = 0;
                m_sec++;
                if (m_alm != 0 && m_sec == m_alm) m_st[0] = 1'b1;
                if (m_rel != 0) begin
                    if (m_cnt == 1) begin m_st[1] = 1'b1; m_cnt = m_rel; end
                    else m_cnt--;
                end
            end
        end
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1 sel = 1; wr = 0; addr = a;
        #1 d = rdata;
        @(posedge clk); #1 sel = 0;
        if (a == A_MS) m_shd = m_vsec;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        logic was_busy;
        was_busy = m_busy();
        @(posedge clk); #1 sel = 1; wr = 1; addr = a; wdata = d;
        @(posedge clk); #1 sel = 0; wr = 0;
        if (!was_busy) begin
            case (a)
                A_SEC: begin m_sec = d; m_vsec = d; m_ms = 0; m_vms = 0; m_acc = 0; end
                A_ALM: m_alm = d;
                A_CDN: begin m_rel = d; m_cnt = d; end
                A_ST:  m_st = m_st & ~d[1:0];
                A_MSK: m_msk = d[1:0];
                default: ;
            endcase
        end
    endtask

    task automatic wr_idle(input logic [7:0] a, input logic [31:0] d);
        while (m_busy()) do_tick();
        bus_wr(a, d);
    endtask

    task automatic chk_reg(input logic [7:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        bus_rd(a, d);
        chk(d, exp, tag);
    endtask

    task automatic chk_irq(input string tag);
        #1 chk({31'b0, irq}, {31'b0, |(m_st & m_msk)}, tag);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_acc = 0; m_ms = 0; m_phase = 0; m_vms = 0;
        m_sec = 0; m_vsec = 0; m_shd = 0; m_alm = 0; m_rel = 0; m_cnt = 0;
        m_st = 0; m_msk = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        chk_reg(A_BUSY, 0, "R1 busy");
        chk_reg(A_SEC, 0, "R1 sec");
        chk_reg(A_SHD, 0, "R1 shadow");
        chk_reg(A_ALM, 0, "R1 alarm");
        chk_reg(A_CDN, 0, "R1 cdown");
        chk_reg(A_ST, 0, "R1 status");
        chk_reg(A_MSK, 0, "R1 mask");
        chk_reg(A_MS, 0, "R1 msec");
        chk_irq("R1 irq");

        // R2 R3 R4 sweep over many seconds, alarm zero (R7 off case)
        for (int i = 0; i < 90; i++) begin
            do_tick();
            chk_reg(A_BUSY, {31'b0, m_busy()}, "R3 busy phase");
            chk_reg(A_MS, m_vms, "R2 msec copy");
            chk_reg(A_SHD, m_shd, "R4 shadow pair");
            chk_reg(A_SEC, m_vsec, "R3 sec copy");
            chk_reg(A_ST, {30'b0, m_st}, "R7 zero alarm no status");
        end

        // R5 seconds load
        wr_idle(A_SEC, 32'd100);
        chk_reg(A_SEC, 32'd100, "R5 sec load");
        chk_reg(A_MS, 0, "R5 msec cleared");
        for (int i = 0; i < 20; i++) begin
            do_tick();
            chk_reg(A_MS, m_vms, "R5 msec after load");
            chk_reg(A_SEC, m_vsec, "R5 sec after load");
        end

        // R6 writes during busy are discarded
        while (!m_busy()) do_tick();
        bus_wr(A_SEC, 32'd55);
        bus_wr(A_ALM, 32'd9);
        bus_wr(A_MSK, 32'd3);
        chk_reg(A_SEC, m_vsec, "R6 sec unchanged");
        chk_reg(A_ALM, 0, "R6 alarm unchanged");
        chk_reg(A_MSK, 0, "R6 mask unchanged");

        // R7 R10 seconds match alarm
        wr_idle(A_SEC, 32'd200);
        wr_idle(A_ALM, 32'd202);
        wr_idle(A_MSK, 32'd1);
        for (int i = 0; i < 30; i++) begin
            do_tick();
            chk_reg(A_ST, {30'b0, m_st}, "R7 alarm status");
            chk_irq("R10 irq alarm");
        end
        chk(m_st[0], 1'b1, "R7 alarm reached");
        // R9 write-one clear
        wr_idle(A_ST, 32'd1);
        chk_reg(A_ST, 0, "R9 w1c alarm");
        chk_irq("R10 irq cleared");

        // R8 countdown, R9 sticky with mask off
        wr_idle(A_ALM, 32'd0);
        wr_idle(A_MSK, 32'd0);
        wr_idle(A_CDN, 32'd2);
        for (int i = 0; i < 50; i++) begin
            do_tick();
            chk_reg(A_ST, {30'b0, m_st}, "R8 countdown status");
            chk_reg(A_CDN, m_cnt, "R8 countdown remaining");
            chk_irq("R10 irq masked");
        end
        chk(m_st[1], 1'b1, "R9 sticky with mask off");
        wr_idle(A_MSK, 32'd2);
        chk_irq("R10 irq countdown");
        chk({31'b0, irq}, 32'd1, "R10 irq asserted");
        wr_idle(A_ST, 32'hFFFF_FFFF);
        chk_reg(A_ST, 0, "R9 clear all");
        chk_irq("R10 irq after clear all");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule